// File: doc/BRIEF.md
# Burst SRAM Address and Command Sequencer

This block is the synchronous front end of a 64K x 32 burst SRAM. On each rising clock edge it samples a 16-bit address, two active-low address strobes, an active-low burst-advance input, three chip enables, the write controls and an order-select input. The write controls are a global write, a byte-write enable and four byte selects. From these samples it produces three registered outputs: the array address, a 4-bit byte-write mask and a cycle kind of deselect, read or write. Each output updates at the same edge that samples the inputs that cause it.

The two strobes behave differently. The processor strobe (`pstb_n`) is ignored while `en1_n` is high, and it always opens a read. The controller strobe (`cstb_n`) opens a read or a write, depending on the write controls. Between strobes, a 2-bit burst counter steps the two low address bits in linear or interleaved order, or holds them when the burst is suspended.

A five-state sequencer tracks the bus. The states are IDLE (deselected), RD1 (first read), WR1 (first write), RDB (burst read) and WRB (burst write). The transitions are:
- A strobe with the device enabled goes from any state to RD1 or WR1.
- A strobe with the device disabled goes from any state to IDLE.
- A cycle with no strobe goes from RD1, WR1, RDB or WRB to RDB or WRB. This is a continue.
- A cycle with no strobe in IDLE stays in IDLE.

Top module: `bsram_ctrl`

## Requirements
- R1: While `rst_n` is low, `seq_state` is 0 (IDLE), `cyc_kind` is 0 (deselect), `byte_wmask` is 0 and `arr_addr` is 0.
- R2: A strobe seen while the device is enabled loads `addr_i` into `arr_addr` at that same edge. A strobe is seen when `cstb_n` is low, or when `pstb_n` and `en1_n` are both low.
- R3: A processor strobe seen while enabled gives `cyc_kind` = 1 (read) and `seq_state` = 1 (RD1), whatever the write controls are.
- R4: A controller strobe seen while enabled, with no processor strobe seen in that cycle, gives a write when the decoded mask is non-zero (`cyc_kind` = 2, `seq_state` = 2 WR1). Otherwise it gives a read (`cyc_kind` = 1, `seq_state` = 1).
- R5: Write decode works as follows.
  - `gwr_n` low sets all four mask bits.
  - Otherwise, `bwen_n` low sets mask bit i for each byte i whose `bsel_n[i]` is low.
  - A mask of zero is a read.
  - `byte_wmask` is zero on every read and deselect cycle.
- R6: The device is enabled only when `en1_n` = 0, `en2` = 1 and `en3_n` = 0.
  - A strobe seen while disabled gives `cyc_kind` = 0 and `seq_state` = 0, and `arr_addr` holds its value.
  - A low `pstb_n` while `en1_n` is high does not count as a strobe.
- R7: When `ord_ilv` was low at load time, each continue with `adv_n` low gives low address bits of (start + count) mod 4.
- R8: When `ord_ilv` was high at load time, each continue with `adv_n` low gives low address bits of start XOR count.
- R9: On the fourth advance, the low address bits return to the loaded start value.
- R10: A continue with `adv_n` high keeps `arr_addr` unchanged and still performs a read or write.
- R11: Throughout a burst, `arr_addr[15:2]` keeps the value it had when it was loaded.
- R12: A continue from RD1, WR1, RDB or WRB goes to WRB (`seq_state` = 4) on a write and to RDB (`seq_state` = 3) on a read. With no strobe, IDLE stays IDLE with `cyc_kind` = 0.
- R13: A strobe in any burst state ends the burst and starts a new first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | 16 | External address |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Byte selects, active low, bit i is byte i |
| ord_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| arr_addr | output | 16 | Registered array address |
| byte_wmask | output | 4 | Registered byte-write mask |
| cyc_kind | output | 2 | 0 deselect, 1 read, 2 write |
| seq_state | output | 3 | 0 IDLE, 1 RD1, 2 WR1, 3 RDB, 4 WRB |

## Verification
The assertions check the following on every cycle:
- The mask is zero outside writes and non-zero on writes.
- The state and the cycle kind agree.
- The upper address bits stay fixed inside a burst.
- A deselect holds the address.
- An enabled processor strobe always yields a read at the sampled address.
- A disabled strobe always yields IDLE.

Only the bench scenarios can show the burst orders themselves: the linear and XOR sequences, the wrap after four advances, suspension, and the order latched at load. The same holds for the masking of the processor strobe by `en1_n` inside a burst. These are compared against a reference model over directed bursts and a long random run.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_WR1  = 3'd2,
        ST_RDB  = 3'd3,
        ST_WRB  = 3'd4
    } bst_state_e;

    typedef enum logic [1:0] {
        CY_NONE = 2'd0,
        CY_RD   = 2'd1,
        CY_WR   = 2'd2
    } bst_cyc_e;

endpackage

// File: rtl/bsram_wdec.sv
module bsram_wdec #(
    parameter int NB = 4
) (
    input  logic          gwr_n,
    input  logic          bwen_n,
    input  logic [NB-1:0] bsel_n,
    output logic [NB-1:0] wmask,
    output logic          wr_any
);
    // one enable term per byte lane
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign wmask[g] = !gwr_n || (!bwen_n && !bsel_n[g]);
    end

    assign wr_any = |wmask;
endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr #(
    parameter int AW = 16,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          ilv_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_nx
);
    localparam int HW = AW - CW;

    logic [HW-1:0] hi_q;
    logic [CW-1:0] base_q;
    logic [CW-1:0] cnt_q;
    logic          ilv_q;
    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] lo_lin;
    logic [CW-1:0] lo_ilv;

    assign cnt_nx = step ? cnt_q + {{(CW-1){1'b0}}, 1'b1} : cnt_q;
    assign lo_lin = base_q + cnt_nx;

    // interleaved order: per-bit XOR of start and count
    for (genvar g = 0; g < CW; g++) begin : g_ilv
        assign lo_ilv[g] = base_q[g] ^ cnt_nx[g];
    end

    always_comb begin
        if (load) begin
            addr_nx = addr_i;
        end else begin
            addr_nx = {hi_q, (ilv_q ? lo_ilv : lo_lin)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b1;
        end else if (load) begin
            hi_q   <= addr_i[AW-1:CW];
            base_q <= addr_i[CW-1:0];
            cnt_q  <= '0;
            ilv_q  <= ilv_i;
        end else if (step) begin
            cnt_q  <= cnt_nx;
        end
    end
endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int AW = 16,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pstb_n,
    input  logic          cstb_n,
    input  logic          adv_n,
    input  logic          en1_n,
    input  logic          en2,
    input  logic          en3_n,
    input  logic [NB-1:0] wmask,
    input  logic          wr_any,
    input  logic [AW-1:0] addr_nx,
    output logic          load,
    output logic          step,
    output bst_state_e    state,
    output bst_cyc_e      cyc_q,
    output logic [NB-1:0] mask_q,
    output logic [AW-1:0] addr_q
);
    logic       proc_hit;
    logic       strobe;
    logic       enabled;
    bst_state_e state_nx;
    bst_cyc_e   cyc_nx;

    assign proc_hit = !pstb_n && !en1_n;
    assign strobe   = proc_hit || !cstb_n;
    assign enabled  = !en1_n && en2 && !en3_n;

    always_comb begin
        state_nx = state;
        cyc_nx   = CY_NONE;
        load     = 1'b0;
        step     = 1'b0;
        if (strobe) begin
            if (!enabled) begin
                state_nx = ST_IDLE;
            end else begin
                load = 1'b1;
                if (proc_hit || !wr_any) begin
                    state_nx = ST_RD1;
                    cyc_nx   = CY_RD;
                end else begin
                    state_nx = ST_WR1;
                    cyc_nx   = CY_WR;
                end
            end
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nx = ST_IDLE;
                end
                ST_RD1, ST_WR1, ST_RDB, ST_WRB: begin
                    step     = !adv_n;
                    state_nx = wr_any ? ST_WRB : ST_RDB;
                    cyc_nx   = wr_any ? CY_WR : CY_RD;
                end
                default: begin
                    state_nx = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= CY_NONE;
            mask_q <= '0;
            addr_q <= '0;
        end else begin
            cyc_q  <= cyc_nx;
            mask_q <= (cyc_nx == CY_WR) ? wmask : '0;
            if (cyc_nx != CY_NONE) begin
                addr_q <= addr_nx;
            end
        end
    end
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int AW = 16,
    parameter int NB = 4,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          pstb_n,
    input  logic          cstb_n,
    input  logic          adv_n,
    input  logic          en1_n,
    input  logic          en2,
    input  logic          en3_n,
    input  logic          gwr_n,
    input  logic          bwen_n,
    input  logic [NB-1:0] bsel_n,
    input  logic          ord_ilv,
    output logic [AW-1:0] arr_addr,
    output logic [NB-1:0] byte_wmask,
    output logic [1:0]    cyc_kind,
    output logic [2:0]    seq_state
);
    logic [NB-1:0] wmask;
    logic          wr_any;
    logic          load;
    logic          step;
    logic [AW-1:0] addr_nx;
    bst_state_e    state;
    bst_cyc_e      cyc_q;

    bsram_wdec #(.NB(NB)) i_wdec (
        .gwr_n  (gwr_n),
        .bwen_n (bwen_n),
        .bsel_n (bsel_n),
        .wmask  (wmask),
        .wr_any (wr_any)
    );

    bsram_burst_ctr #(.AW(AW), .CW(CW)) i_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .ilv_i   (ord_ilv),
        .addr_i  (addr_i),
        .addr_nx (addr_nx)
    );

    bsram_seq #(.AW(AW), .NB(NB)) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pstb_n  (pstb_n),
        .cstb_n  (cstb_n),
        .adv_n   (adv_n),
        .en1_n   (en1_n),
        .en2     (en2),
        .en3_n   (en3_n),
        .wmask   (wmask),
        .wr_any  (wr_any),
        .addr_nx (addr_nx),
        .load    (load),
        .step    (step),
        .state   (state),
        .cyc_q   (cyc_q),
        .mask_q  (byte_wmask),
        .addr_q  (arr_addr)
    );

    assign cyc_kind  = cyc_q;
    assign seq_state = state;
endmodule

// File: rtl/bsram_ctrl_chk.sv
module bsram_ctrl_chk #(
    parameter int AW = 16,
    parameter int NB = 4,
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_i,
    input logic          pstb_n,
    input logic          cstb_n,
    input logic          en1_n,
    input logic          en2,
    input logic          en3_n,
    input logic [AW-1:0] arr_addr,
    input logic [NB-1:0] byte_wmask,
    input logic [1:0]    cyc_kind,
    input logic [2:0]    seq_state
);
    // R5: no mask outside writes
    a_r5_mask_zero_nonwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind != 2'd2) |-> (byte_wmask == '0));

    // R5: a write always enables at least one byte
    a_r5_mask_set_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 2'd2) |-> (byte_wmask != '0));

    // R12: state and cycle kind agree
    a_r12_state_matches_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_state == 3'd2) || (seq_state == 3'd4)) == (cyc_kind == 2'd2));

    // R11: upper bits fixed inside a burst
    a_r11_upper_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_state == 3'd3) || (seq_state == 3'd4)) |->
        (arr_addr[AW-1:CW] == $past(arr_addr[AW-1:CW])));

    // R6: deselect holds the address
    a_r6_desel_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == 2'd0) |-> $stable(arr_addr));

    // R3: enabled processor strobe yields read at sampled address
    a_r3_proc_strobe_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && !en1_n && en2 && !en3_n) |=>
        ((cyc_kind == 2'd1) && (seq_state == 3'd1) && (arr_addr == $past(addr_i))));

    // R6: strobe while disabled gives deselect
    a_r6_disabled_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cstb_n || (!pstb_n && !en1_n)) && !(!en1_n && en2 && !en3_n)) |=>
        ((seq_state == 3'd0) && (cyc_kind == 2'd0)));
endmodule

bind bsram_ctrl bsram_ctrl_chk #(.AW(AW), .NB(NB), .CW(CW)) i_chk (.*);

// File: tb/test_bsram_ctrl.sv
module test_bsram_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_i = '0;
    logic        pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
    logic        en1_n = 1'b0, en2 = 1'b1, en3_n = 1'b0;
    logic        gwr_n = 1'b1, bwen_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic        ord_ilv = 1'b0;
    logic [15:0] arr_addr;
    logic [3:0]  byte_wmask;
    logic [1:0]  cyc_kind;
    logic [2:0]  seq_state;

    int n_chk = 0;
    int n_fail = 0;

    // reference model
    logic [13:0] m_hi = '0;
    logic [1:0]  m_base = '0, m_cnt = '0;
    logic        m_ilv = 1'b1;
    logic [2:0]  m_state = '0;
    logic [15:0] e_addr = '0;
    logic [1:0]  e_cyc = '0;
    logic [3:0]  e_mask = '0;
    string       m_tag = "R1";

    always #4 clk = ~clk;

    bsram_ctrl i_bsram_ctrl (.*);

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] dec_mask();
        if (!gwr_n) return 4'hF;
        if (!bwen_n) return ~bsel_n;
        return 4'h0;
    endfunction

    task automatic model_step();
        logic       proc, stb, en;
        logic [3:0] mk;
        logic [1:0] lo;
        proc = !pstb_n && !en1_n;
        stb  = proc || !cstb_n;
        en   = !en1_n && en2 && !en3_n;
        mk   = dec_mask();
        if (stb && !en) begin
            m_state = 3'd0; e_cyc = 2'd0; m_tag = "R6";
        end else if (stb) begin
            m_hi = addr_i[15:2]; m_base = addr_i[1:0]; m_cnt = 2'd0; m_ilv = ord_ilv;
            e_addr = addr_i;
            if (proc || mk == 4'h0) begin
                e_cyc = 2'd1; m_state = 3'd1; m_tag = proc ? "R3" : "R4";
            end else begin
                e_cyc = 2'd2; m_state = 3'd2; m_tag = "R4";
            end
        end else if (m_state == 3'd0) begin
            e_cyc = 2'd0; m_tag = "R12";
        end else begin
            if (!adv_n) begin
                m_cnt = m_cnt + 2'd1;
                m_tag = m_ilv ? "R8" : "R7";
            end else begin
                m_tag = "R10";
            end
            lo = m_ilv ? (m_base ^ m_cnt) : (m_base + m_cnt);
            e_addr = {m_hi, lo};
            e_cyc = (mk != 4'h0) ? 2'd2 : 2'd1;
            m_state = (mk != 4'h0) ? 3'd4 : 3'd3;
        end
        e_mask = (e_cyc == 2'd2) ? mk : 4'h0;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(m_tag, arr_addr, e_addr);
        chk(m_tag, cyc_kind, e_cyc);
        chk("R5", byte_wmask, e_mask);
        chk(m_tag, seq_state, m_state);
    endtask

    task automatic drv(input logic sp, input logic sc, input logic av,
                       input logic e1, input logic e2, input logic e3,
                       input logic gw, input logic bw, input logic [3:0] bs,
                       input logic ord, input logic [15:0] a);
        pstb_n = sp; cstb_n = sc; adv_n = av;
        en1_n = e1; en2 = e2; en3_n = e3;
        gwr_n = gw; bwen_n = bw; bsel_n = bs; ord_ilv = ord; addr_i = a;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", arr_addr, 16'h0);
        chk("R1", cyc_kind, 2'd0);
        chk("R1", byte_wmask, 4'h0);
        chk("R1", seq_state, 3'd0);
        rst_n = 1'b1;

        drv(1,1,1, 0,1,0, 1,1,4'hF, 0, 16'h0000); tick();          // R12 idle stays
        drv(0,1,1, 0,1,0, 0,1,4'hF, 0, 16'h1235); tick();          // R3 proc read despite gw
        chk("R2", arr_addr, 16'h1235);
        drv(1,1,0, 0,1,0, 1,1,4'hF, 0, 16'h0000); tick();          // R7 linear 10
        chk("R7", arr_addr, 16'h1236);
        tick(); tick(); tick();                                     // 11,00,01
        chk("R9", arr_addr, 16'h1235);
        chk("R11", arr_addr[15:2], 14'h048D);
        drv(1,1,1, 0,1,0, 1,1,4'hF, 0, 16'h0000); tick();          // R10 suspend
        chk("R10", arr_addr, 16'h1235);
        drv(0,1,0, 1,1,0, 1,1,4'hF, 0, 16'hFFFF); tick();          // R6 e1 blocks pstb
        chk("R6", arr_addr, 16'h1236);
        chk("R6", seq_state, 3'd3);
        drv(1,0,1, 0,1,0, 0,1,4'hF, 1, 16'hABCE); tick();          // R13 new write
        chk("R13", seq_state, 3'd2);
        chk("R5", byte_wmask, 4'hF);
        drv(1,1,0, 0,1,0, 1,0,4'b1010, 1, 16'h0000); tick();       // R8 interleave
        chk("R8", arr_addr, 16'hABCF);
        chk("R5", byte_wmask, 4'b0101);
        chk("R12", seq_state, 3'd4);
        drv(1,1,0, 0,1,0, 1,1,4'hF, 1, 16'h0000); tick(); tick();
        chk("R8", arr_addr, 16'hABCD);
        drv(1,0,1, 0,0,0, 0,1,4'hF, 0, 16'h5555); tick();          // R6 disabled strobe
        chk("R6", arr_addr, 16'hABCD);
        chk("R6", cyc_kind, 2'd0);
        drv(1,0,1, 0,1,0, 1,0,4'hF, 0, 16'h2222); tick();          // R5 no byte -> read
        chk("R5", cyc_kind, 2'd1);
        chk("R4", seq_state, 3'd1);
        drv(0,1,1, 0,1,1, 1,1,4'hF, 0, 16'h3333); tick();          // R6 e3 high
        chk("R6", seq_state, 3'd0);

        for (int i = 0; i < 3000; i++) begin
            drv(($urandom % 100) >= 15, ($urandom % 100) >= 20, ($urandom % 100) >= 70,
                ($urandom % 100) >= 85, ($urandom % 100) < 90, ($urandom % 100) >= 90,
                ($urandom % 100) >= 20, ($urandom % 100) >= 40, 4'($urandom),
                1'($urandom), 16'($urandom));
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule